// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This block manages low-power states for a small processor core. When software sets a sleep-enable control bit and the core signals that it has executed its sleep instruction, the controller picks one of four depths from a 3-bit mode field. It halts the core and switches off the clock domains that this depth does not need. While asleep it watches a vector of eight wake requests, each already qualified by its own enable. Only the sources that the selected depth accepts can wake it.

On a qualified wake the controller brings the clocks back. From the deepest state it first waits for the clock system to report that its oscillator has started. It then keeps the core halted for a fixed number of extra cycles. When it releases the core, it also reports whether execution continues at the wake interrupt, just after the sleep instruction, or at the reset vector. A wake-time reset request selects the reset vector. The charger-detect source is honoured only while the external discharge switch is off. A wake that arrives in the same cycle as the entry request cancels the entry. The controller never writes to or resets the register file or SRAM.

Top module: `sleep_ctrl`

## Requirements
- R1: A `sleep_exec` pulse sampled with `sleep_en` = 1 moves the block from running to asleep, so `core_halt` rises on the next cycle. With `sleep_en` = 0 the pulse is ignored: `core_halt` stays 0 and all clocks stay enabled.
- R2: Mode field encoding: 000 idle, 001 ADC noise reduction, 011 power-save, 010 power-off. The codes 1xx are treated as idle.
- R3: Wake source bit positions: 0 battery protection, 1 external interrupt, 2 watchdog, 3 EEPROM ready, 4 regulator monitor, 5 ADC, 6 other I/O, 7 charger detect. Idle accepts all eight. ADC noise reduction accepts all except bit 6. Power-save accepts bits 0 to 2. Power-off accepts bit 7 only. A request outside the mask leaves the block asleep with unchanged clock enables.
- R4: Bit 7 (charger detect) wakes the block only while `dsch_on` is 0.
- R5: After an interrupt wake from idle, ADC noise reduction or power-save, `core_halt` stays 1 for exactly 4 cycles after the wake edge with all clocks enabled. It then falls, with `resume_vec` = 0 (continue after the sleep instruction).
- R6: After a wake from power-off, all clocks stay off and `core_halt` stays 1 until `startup_done` is sampled high. The 4-cycle halt of R5 then follows.
- R7: `reset_wake` sampled while asleep wakes the block from any mode, following the R5/R6 timing, and leaves `resume_vec` = 1 (reset vector). `reset_wake` while running has no effect on any output.
- R8: `clk_en` bit order: 0 CPU, 1 I/O, 2 ADC, 3 slow timer. Running: 1111. Idle: 1110. ADC noise reduction: 1100. Power-save: 1000. Power-off and start-up wait: 0000.
- R9: A qualified wake in the same cycle as a valid entry request aborts the entry. The block goes straight to the 4-cycle halt with all clocks on and no start-up wait, even for power-off.
- R10: After block reset the outputs are: `core_halt` 0, `clk_en` 1111, `resume_vec` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (always running) |
| rst_n | input | 1 | Active-low asynchronous block reset |
| sleep_en | input | 1 | Sleep enable control bit |
| sleep_mode | input | 3 | Sleep depth select |
| sleep_exec | input | 1 | One-cycle pulse: core executed the sleep instruction |
| wake_req | input | 8 | Enabled wake requests, one bit per source |
| dsch_on | input | 1 | External discharge switch is on |
| reset_wake | input | 1 | Reset request arriving during sleep |
| startup_done | input | 1 | Oscillator start-up complete |
| clk_en | output | 4 | Per-domain clock enables |
| core_halt | output | 1 | Hold the core |
| resume_vec | output | 1 | 1 = resume at reset vector, 0 = after sleep instruction |

## Verification
The assertions assume that `sleep_exec` is a single-cycle pulse and that `startup_done` is only meaningful while the block waits in the power-off start-up state. They also assume that `reset_wake` is a level sampled on clock edges. The stimulus drives every input on the falling edge and holds `sleep_exec`, wake pulses and `startup_done` for one cycle. It never raises them during the halt window except when testing that they are ignored. Random mode codes include the unused 1xx codes. Random wake vectors and the discharge-switch level are drawn from a fixed seed, so requests both inside and outside each mask occur.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
   localparam int NUM_DOM = 4;
   localparam int DOM_CPU = 0;
   localparam int DOM_IO  = 1;
   localparam int DOM_ADC = 2;
   localparam int DOM_TMR = 3;

   typedef enum logic [1:0] {M_IDLE, M_ADCNR, M_PSAVE, M_POFF} depth_t;
   typedef enum logic [1:0] {S_RUN, S_SLEEP, S_START, S_HALT} ctl_state_t;

   function automatic depth_t decode_depth(input logic [2:0] code);
      case (code)
         3'b001:  decode_depth = M_ADCNR;
         3'b011:  decode_depth = M_PSAVE;
         3'b010:  decode_depth = M_POFF;
         default: decode_depth = M_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter
   import sleep_pkg::*;
#(
   parameter int              NUM_SRC    = 8,
   parameter int              CHG_BIT    = 7,
   parameter bit              GATE_CHG   = 1'b1,
   parameter logic [NUM_SRC-1:0] MASK_IDLE  = 8'hFF,
   parameter logic [NUM_SRC-1:0] MASK_ADCNR = 8'hBF,
   parameter logic [NUM_SRC-1:0] MASK_PSAVE = 8'h07,
   parameter logic [NUM_SRC-1:0] MASK_POFF  = 8'h80
) (
   input  depth_t             depth,
   input  logic [NUM_SRC-1:0] wake_req,
   input  logic               dsch_on,
   output logic               wake_hit
);
   logic [NUM_SRC-1:0] depth_mask;
   logic [NUM_SRC-1:0] src_ok;

   generate
      if (CHG_BIT >= NUM_SRC) begin : g_bad_chg
         $error("CHG_BIT must index a wake source");
      end
   endgenerate

   always_comb begin
      case (depth)
         M_ADCNR: depth_mask = MASK_ADCNR;
         M_PSAVE: depth_mask = MASK_PSAVE;
         M_POFF:  depth_mask = MASK_POFF;
         default: depth_mask = MASK_IDLE;
      endcase
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (GATE_CHG && i == CHG_BIT) begin : g_chg
         assign src_ok[i] = wake_req[i] & depth_mask[i] & ~dsch_on;
      end else begin : g_plain
         assign src_ok[i] = wake_req[i] & depth_mask[i];
      end
   end

   assign wake_hit = |src_ok;
endmodule

// File: rtl/sleep_clk_gate.sv
module sleep_clk_gate
   import sleep_pkg::*;
#(
   parameter logic [NUM_DOM-1:0] EN_IDLE  = 4'b1110,
   parameter logic [NUM_DOM-1:0] EN_ADCNR = 4'b1100,
   parameter logic [NUM_DOM-1:0] EN_PSAVE = 4'b1000,
   parameter logic [NUM_DOM-1:0] EN_POFF  = 4'b0000
) (
   input  ctl_state_t         state,
   input  depth_t             depth,
   output logic [NUM_DOM-1:0] clk_en
);
   logic [NUM_DOM-1:0] sleep_pat;

   always_comb begin
      case (depth)
         M_ADCNR: sleep_pat = EN_ADCNR;
         M_PSAVE: sleep_pat = EN_PSAVE;
         M_POFF:  sleep_pat = EN_POFF;
         default: sleep_pat = EN_IDLE;
      endcase
   end

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      always_comb begin
         case (state)
            S_SLEEP: clk_en[d] = sleep_pat[d];
            S_START: clk_en[d] = 1'b0;
            default: clk_en[d] = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
   import sleep_pkg::*;
#(
   parameter int NUM_SRC     = 8,
   parameter int CHG_BIT     = 7,
   parameter int HALT_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_en,
   input  logic [2:0]         sleep_mode,
   input  logic               sleep_exec,
   input  logic [NUM_SRC-1:0] wake_req,
   input  logic               dsch_on,
   input  logic               reset_wake,
   input  logic               startup_done,
   output logic [NUM_DOM-1:0] clk_en,
   output logic               core_halt,
   output logic               resume_vec
);
   localparam int CW = $clog2(HALT_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(HALT_CYCLES - 1);

   generate
      if (HALT_CYCLES < 1) begin : g_bad_halt
         $error("HALT_CYCLES must be at least 1");
      end
   endgenerate

   ctl_state_t      state_q, state_d;
   depth_t          depth_q, depth_d, filt_depth;
   logic [CW-1:0]   cnt_q, cnt_d;
   logic            vec_q, vec_d;
   logic            wake_hit;
   logic            enter_req;

   assign enter_req  = sleep_exec & sleep_en;
   assign filt_depth = (state_q == S_RUN) ? decode_depth(sleep_mode) : depth_q;

   sleep_wake_filter #(.NUM_SRC(NUM_SRC), .CHG_BIT(CHG_BIT)) u_filt (
      .depth    (filt_depth),
      .wake_req (wake_req),
      .dsch_on  (dsch_on),
      .wake_hit (wake_hit)
   );

   sleep_clk_gate u_gate (
      .state  (state_q),
      .depth  (depth_q),
      .clk_en (clk_en)
   );

   always_comb begin
      state_d = state_q;
      depth_d = depth_q;
      cnt_d   = cnt_q;
      vec_d   = vec_q;
      case (state_q)
         S_RUN: begin
            if (enter_req) begin
               depth_d = filt_depth;
               vec_d   = 1'b0;
               cnt_d   = '0;
               state_d = wake_hit ? S_HALT : S_SLEEP;
            end
         end
         S_SLEEP: begin
            if (reset_wake || wake_hit) begin
               vec_d   = reset_wake;
               cnt_d   = '0;
               state_d = (depth_q == M_POFF) ? S_START : S_HALT;
            end
         end
         S_START: begin
            if (startup_done) begin
               cnt_d   = '0;
               state_d = S_HALT;
            end
         end
         default: begin
            if (cnt_q == CNT_LAST) begin
               state_d = S_RUN;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_RUN;
         depth_q <= M_IDLE;
         cnt_q   <= '0;
         vec_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         depth_q <= depth_d;
         cnt_q   <= cnt_d;
         vec_q   <= vec_d;
      end
   end

   assign core_halt  = (state_q != S_RUN);
   assign resume_vec = vec_q;

   // R1: entry request without sleep enable keeps the core running
   p_no_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RUN && sleep_exec && !sleep_en) |=> !core_halt);

   // R8: CPU clock is off whenever the block is asleep
   p_cpu_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_SLEEP) |-> !clk_en[DOM_CPU]);

   // R6: start-up wait holds until the clock system reports ready
   p_start_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_START && !startup_done) |=> (state_q == S_START && clk_en == '0));

   // R5: release happens only at the end of the halt window
   p_halt_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_halt) |-> ($past(state_q) == S_HALT && $past(cnt_q) == CNT_LAST));

   // R7: reset request during sleep selects the reset vector
   p_reset_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_SLEEP && reset_wake) |=> resume_vec);

   // R9: aborted entry never enters the start-up wait
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RUN && enter_req && wake_hit) |=> (state_q == S_HALT && clk_en == '1));
endmodule

// File: tb/sim_sleep_ctrl.sv
module sim_sleep_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_en = 1'b0;
   logic [2:0] sleep_mode = 3'b000;
   logic       sleep_exec = 1'b0;
   logic [7:0] wake_req = 8'h00;
   logic       dsch_on = 1'b0;
   logic       reset_wake = 1'b0;
   logic       startup_done = 1'b0;
   logic [3:0] clk_en;
   logic       core_halt;
   logic       resume_vec;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sleep_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_mode(sleep_mode),
      .sleep_exec(sleep_exec), .wake_req(wake_req), .dsch_on(dsch_on),
      .reset_wake(reset_wake), .startup_done(startup_done),
      .clk_en(clk_en), .core_halt(core_halt), .resume_vec(resume_vec)
   );

   // depth index: 0 idle, 1 adc nr, 2 power-save, 3 power-off (R2)
   function automatic int exp_depth(input logic [2:0] c);
      case (c)
         3'b001:  return 1;
         3'b011:  return 2;
         3'b010:  return 3;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] exp_mask(input int d, input logic dsch);
      logic [7:0] m;
      case (d)
         1:       m = 8'hBF;
         2:       m = 8'h07;
         3:       m = 8'h80;
         default: m = 8'hFF;
      endcase
      if (dsch) m[7] = 1'b0;
      return m;
   endfunction

   function automatic logic [3:0] exp_clk(input int d);
      case (d)
         1:       return 4'b1100;
         2:       return 4'b1000;
         3:       return 4'b0000;
         default: return 4'b1110;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // called at the falling edge right after the edge that starts the halt window
   task automatic halt_seq(input logic vec, input string req);
      for (int i = 0; i < 4; i++) begin
         chk(core_halt === 1'b1 && clk_en === 4'hF, req, {clk_en, 3'b0, core_halt}, 32'hF1);
         @(negedge clk);
      end
      chk(core_halt === 1'b0, req, core_halt, 0);
      chk(resume_vec === vec, req, resume_vec, vec);
   endtask

   task automatic wake_now(input logic [7:0] w, input logic rw, input int d);
      wake_req = w; reset_wake = rw;
      @(negedge clk);
      wake_req = 8'h00; reset_wake = 1'b0;
      if (d == 3) begin
         for (int i = 0; i < 3; i++) begin
            chk(core_halt === 1'b1 && clk_en === 4'h0, "R6", {clk_en, 3'b0, core_halt}, 32'h01);
            @(negedge clk);
         end
         startup_done = 1'b1;
         @(negedge clk);
         startup_done = 1'b0;
      end
      halt_seq(rw, rw ? "R7" : "R5");
   endtask

   task automatic sleep_cycle(input logic [2:0] code, input logic [7:0] w, input logic dsch);
      int d;
      logic [7:0] m;
      d = exp_depth(code);
      m = exp_mask(d, dsch);
      dsch_on = dsch; sleep_en = 1'b1; sleep_mode = code; sleep_exec = 1'b1;
      @(negedge clk);
      sleep_exec = 1'b0;
      chk(core_halt === 1'b1, "R1", core_halt, 1);
      chk(clk_en === exp_clk(d), "R8/R2", clk_en, exp_clk(d));
      if ((w & m) != 8'h00) begin
         wake_now(w, 1'b0, d);
      end else begin
         wake_req = w;
         @(negedge clk);
         wake_req = 8'h00;
         chk(core_halt === 1'b1 && clk_en === exp_clk(d), (w[7] && dsch) ? "R4" : "R3",
             {clk_en, 3'b0, core_halt}, {exp_clk(d), 4'h1});
         if (m != 8'h00) wake_now(m & (~m + 8'h01), 1'b0, d);
         else            wake_now(8'h00, 1'b1, d);
      end
      sleep_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(core_halt === 1'b0 && clk_en === 4'hF && resume_vec === 1'b0, "R10",
          {clk_en, 2'b0, resume_vec, core_halt}, 32'hF0);

      // R1: pulse without enable is ignored
      sleep_en = 1'b0; sleep_exec = 1'b1; sleep_mode = 3'b010;
      @(negedge clk);
      sleep_exec = 1'b0;
      chk(core_halt === 1'b0 && clk_en === 4'hF, "R1", {clk_en, 3'b0, core_halt}, 32'hF0);

      // R7: reset request while running has no effect
      reset_wake = 1'b1;
      @(negedge clk);
      reset_wake = 1'b0;
      chk(core_halt === 1'b0 && resume_vec === 1'b0 && clk_en === 4'hF, "R7",
          {clk_en, 2'b0, resume_vec, core_halt}, 32'hF0);

      // R2: unused code acts as idle; R3: ADC-NR ignores other I/O
      sleep_cycle(3'b111, 8'h40, 1'b0);
      sleep_cycle(3'b001, 8'h40, 1'b0);
      // R4: charger detect blocked by discharge switch in power-off, then reset wake
      sleep_cycle(3'b010, 8'h80, 1'b1);
      // R4/R6: charger detect honoured with switch off
      sleep_cycle(3'b010, 8'h80, 1'b0);
      // R3: power-save rejects ADC, accepts watchdog
      sleep_cycle(3'b011, 8'h20, 1'b0);
      sleep_cycle(3'b011, 8'h04, 1'b0);

      // R9: abort on wake in the entry cycle, power-off with charger
      dsch_on = 1'b0; sleep_en = 1'b1; sleep_mode = 3'b010; sleep_exec = 1'b1; wake_req = 8'h80;
      @(negedge clk);
      sleep_exec = 1'b0; wake_req = 8'h00; sleep_en = 1'b0;
      halt_seq(1'b0, "R9");

      // R7: reset wake from idle
      sleep_en = 1'b1; sleep_mode = 3'b000; sleep_exec = 1'b1;
      @(negedge clk);
      sleep_exec = 1'b0; sleep_en = 1'b0;
      wake_now(8'h00, 1'b1, 0);

      for (int it = 0; it < 60; it++) begin
         logic [2:0] c;
         logic [7:0] w;
         logic       ds;
         c  = 3'($urandom_range(0, 7));
         w  = 8'($urandom_range(0, 255));
         ds = 1'($urandom_range(0, 1));
         if (($urandom_range(0, 3)) == 0) w = 8'h00;
         sleep_cycle(c, w, ds);
         repeat (int'($urandom_range(0, 3))) @(negedge clk);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule